// File: doc/BRIEF.md
# Shared-Bus SRAM and Flash Interface

This block sits on the host side of a 32-bit asynchronous memory module. The module holds four byte-wide SRAM dies and four byte-wide flash dies. All eight dies share one 19-bit address bus and one 32-bit data bus. The SRAM region is 128K words and uses the low 17 address bits. The flash region is 512K words and uses all 19 bits.

The host issues one request at a time through a valid/ready handshake. A request carries an address, write data, a byte-lane mask, a read/write flag and a target flag that picks SRAM or flash. The controller drives a shared output enable, one chip enable per memory type and four byte-lane write enables per memory type. It holds each phase for a whole number of clock cycles. The cycle counts are parameters, found by rounding each nanosecond limit up against the clock period.

Read data is sampled in the last cycle of the strobe and returned with a one-cycle done pulse. The controller inserts idle cycles in three places:
- on the bus between accesses of different type or direction;
- between consecutive flash writes, to meet the write-enable high time;
- after each write strobe, to cover the data hold window, during which the write data stays driven.

Top module: `dual_mem_bus_ctrl`

## Requirements
- R1: After reset: both chip enables, the output enable and all eight write enables are high (inactive); `mem_dq_oe` and `done` are 0; `req_ready` is 1.
- R2: An SRAM read holds `sram_ce_n` and `mem_oe_n` low for exactly SRAM_RD_CYC cycles. `rd_data` returns the value on `mem_dq_in` in the last of those cycles.
- R3: A flash read holds `flash_ce_n` and `mem_oe_n` low for exactly FLASH_RD_CYC cycles. `rd_data` returns the value on `mem_dq_in` in the last of those cycles.
- R4: In a write, mask bit i selects byte lane i (data bits 8i+7..8i). Only the selected write enables of the target type go low, for exactly SRAM_WP_CYC (SRAM) or FLASH_WP_CYC (flash) cycles. The other type's write enables and the unselected lanes stay high. A mask of 0 strobes no lane and keeps the same timing.
- R5: For a write, `mem_dq_oe` is high for exactly the write strobe plus HOLD_CYC cycles, and the chip enable stays low through the hold cycles. `mem_dq_oe` is low during reads and while no chip enable is low. `mem_addr` is stable while a chip enable is low.
- R6: `sram_ce_n` and `flash_ce_n` are never low in the same cycle.
- R7: If an access differs from the previous accepted one in target or in direction, TURN_CYC idle cycles (all enables inactive) come before its strobe.
- R8: A flash write that follows a flash write is preceded by FLASH_WPH_CYC idle cycles.
- R9: `req_ready` is high only when the controller is idle, and a request is taken on a clock edge with `req_valid` and `req_ready` both high. From that edge, `done` rises after gap + strobe cycles for a read, and after gap + strobe + HOLD_CYC cycles for a write. `done` lasts one cycle, and `req_ready` is high in that cycle.
- R10: The first access after reset, and an access of the same target and direction as the previous one (apart from the R8 case), start their strobe with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane mask for writes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_flash | input | 1 | 1 = flash, 0 = SRAM |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result, valid with `done` after a read |
| mem_addr | output | 19 | Shared address bus |
| mem_dq_out | output | 32 | Write data to the bus |
| mem_dq_oe | output | 1 | Enable of the write-data driver |
| mem_dq_in | input | 32 | Data from the bus |
| mem_oe_n | output | 1 | Shared output enable, active low |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| sram_we_n | output | 4 | SRAM byte-lane write enables, active low |
| flash_we_n | output | 4 | Flash byte-lane write enables, active low |

## Verification
A wrong phase counter shows up on the first access of the affected type, as a strobe of the wrong length and a shifted `done`. A read that samples too early returns the bench's filler pattern, because the bench memory model drives valid data only once the full access time has passed.

A wrong gap or history register shows up only on the second access of a pair. The bench therefore runs every ordered pair of {SRAM, flash} × {read, write} back to back and checks the `done` latency exactly. Lane-mapping errors appear as a wrong read-back value on the next read of that word.

// File: rtl/dual_mem_bus_ctrl.sv
module dual_mem_bus_ctrl #(
  parameter int AW            = 19,
  parameter int DW            = 32,
  parameter int SRAM_RD_CYC   = 9,
  parameter int SRAM_WP_CYC   = 7,
  parameter int FLASH_RD_CYC  = 23,
  parameter int FLASH_WP_CYC  = 12,
  parameter int FLASH_WPH_CYC = 5,
  parameter int HOLD_CYC      = 1,
  parameter int TURN_CYC      = 1,
  localparam int LANES        = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  input  logic             req_write,
  input  logic             req_flash,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in,
  output logic             mem_oe_n,
  output logic             sram_ce_n,
  output logic             flash_ce_n,
  output logic [LANES-1:0] sram_we_n,
  output logic [LANES-1:0] flash_we_n
);

  localparam int M1   = SRAM_RD_CYC > SRAM_WP_CYC ? SRAM_RD_CYC : SRAM_WP_CYC;
  localparam int M2   = FLASH_RD_CYC > FLASH_WP_CYC ? FLASH_RD_CYC : FLASH_WP_CYC;
  localparam int M3   = FLASH_WPH_CYC > TURN_CYC ? FLASH_WPH_CYC : TURN_CYC;
  localparam int M4   = M1 > M2 ? M1 : M2;
  localparam int M5   = M3 > HOLD_CYC ? M3 : HOLD_CYC;
  localparam int MAXC = M4 > M5 ? M4 : M5;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_STRB, S_HOLD} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rd_q;
  logic [LANES-1:0] be_q;
  logic            wr_q, fl_q, done_q;
  logic            prev_v, prev_wr, prev_fl;

  function automatic logic [CW-1:0] strobe_len(input logic fl, input logic wr);
    case ({fl, wr})
      2'b00:   return CW'(SRAM_RD_CYC);
      2'b01:   return CW'(SRAM_WP_CYC);
      2'b10:   return CW'(FLASH_RD_CYC);
      default: return CW'(FLASH_WP_CYC);
    endcase
  endfunction

  wire accept   = req_valid && (st == S_IDLE);
  wire switched = prev_v && ((prev_fl != req_flash) || (prev_wr != req_write));
  wire fl_ww    = prev_v && prev_fl && prev_wr && req_flash && req_write;
  wire [CW-1:0] gap_len = switched ? CW'(TURN_CYC) : (fl_ww ? CW'(FLASH_WPH_CYC) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      fl_q    <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      prev_v  <= 1'b0;
      prev_wr <= 1'b0;
      prev_fl <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          wr_q    <= req_write;
          fl_q    <= req_flash;
          prev_v  <= 1'b1;
          prev_wr <= req_write;
          prev_fl <= req_flash;
          if (gap_len != '0) begin
            st  <= S_GAP;
            cnt <= gap_len - CW'(1);
          end else begin
            st  <= S_STRB;
            cnt <= strobe_len(req_flash, req_write) - CW'(1);
          end
        end
        S_GAP: begin
          if (cnt == '0) begin
            st  <= S_STRB;
            cnt <= strobe_len(fl_q, wr_q) - CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_STRB: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (!wr_q) begin
            rd_q   <= mem_dq_in;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (HOLD_CYC > 0) begin
            st  <= S_HOLD;
            cnt <= CW'(HOLD_CYC - 1);
          end else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: begin
          if (cnt == '0) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end

  wire active = (st == S_STRB) || (st == S_HOLD);
  wire strobe = (st == S_STRB);

  assign req_ready  = (st == S_IDLE);
  assign done       = done_q;
  assign rd_data    = rd_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = active && wr_q;
  assign mem_oe_n   = !(strobe && !wr_q);
  assign sram_ce_n  = !(active && !fl_q);
  assign flash_ce_n = !(active && fl_q);
  assign sram_we_n  = (strobe && wr_q && !fl_q) ? ~be_q : {LANES{1'b1}};
  assign flash_we_n = (strobe && wr_q && fl_q) ? ~be_q : {LANES{1'b1}};

endmodule

// File: rtl/dual_mem_bus_ctrl_chk.sv
module dual_mem_bus_ctrl_chk #(
  parameter int AW    = 19,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_dq_oe,
  input logic             mem_oe_n,
  input logic             sram_ce_n,
  input logic             flash_ce_n,
  input logic [LANES-1:0] sram_we_n,
  input logic [LANES-1:0] flash_we_n
);

  p_ce_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_ce_n && !flash_ce_n));

  p_dq_off_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_dq_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_ce_n && flash_ce_n) |-> !mem_dq_oe);

  p_sram_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_n != {LANES{1'b1}}) |-> (!sram_ce_n && mem_dq_oe && mem_oe_n));

  p_flash_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_we_n != {LANES{1'b1}}) |-> (!flash_ce_n && mem_dq_oe && mem_oe_n));

  p_sram_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(mem_addr));

  p_flash_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(mem_addr));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && flash_ce_n && mem_oe_n));

endmodule

bind dual_mem_bus_ctrl dual_mem_bus_ctrl_chk #(.AW(AW), .LANES(LANES)) u_chk (.*);

// File: tb/dual_mem_bus_ctrl_bench.sv
`timescale 1ns/1ps
module dual_mem_bus_ctrl_bench;
  localparam int T_SR = 3, T_SW = 2, T_FR = 5, T_FW = 4, T_WPH = 3, T_HOLD = 1, T_TURN = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, req_flash, done, mem_dq_oe;
  logic [18:0] req_addr, mem_addr;
  logic [31:0] req_wdata, rd_data, mem_dq_out, mem_dq_in;
  logic [3:0]  req_be, sram_we_n, flash_we_n;
  logic        mem_oe_n, sram_ce_n, flash_ce_n;

  dual_mem_bus_ctrl #(
    .SRAM_RD_CYC(T_SR), .SRAM_WP_CYC(T_SW), .FLASH_RD_CYC(T_FR), .FLASH_WP_CYC(T_FW),
    .FLASH_WPH_CYC(T_WPH), .HOLD_CYC(T_HOLD), .TURN_CYC(T_TURN)
  ) u_dual_mem_bus_ctrl (.*);

  logic [31:0] dev_s [16], dev_f [16], shd_s [16], shd_f [16];
  int rd_cnt = 0;
  int errors = 0, checks = 0;
  int v_ce = 0, v_dq = 0, v_addr = 0;
  int we_len, oe_len, dq_len;
  logic [3:0] we_mask;
  bit we_s, we_f, saw_s, saw_f;
  logic [18:0] cur_addr;
  bit have_prev = 0, p_fl = 0, p_wr = 0, finished = 0;

  assign mem_dq_in = (!mem_oe_n && !sram_ce_n && rd_cnt >= T_SR - 1) ? dev_s[mem_addr[3:0]] :
                     (!mem_oe_n && !flash_ce_n && rd_cnt >= T_FR - 1) ? dev_f[mem_addr[3:0]] :
                     32'hA5A5_5A5A;

  always @(posedge clk) begin
    rd_cnt <= (!mem_oe_n && (!sram_ce_n || !flash_ce_n)) ? rd_cnt + 1 : 0;
    for (int l = 0; l < 4; l++) begin
      if (!sram_ce_n && !sram_we_n[l])  dev_s[mem_addr[3:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
      if (!flash_ce_n && !flash_we_n[l]) dev_f[mem_addr[3:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (!sram_ce_n && !flash_ce_n) v_ce++;
    if (mem_dq_oe && (!mem_oe_n || (sram_ce_n && flash_ce_n))) v_dq++;
    if ((sram_we_n != 4'hF || flash_we_n != 4'hF) && !mem_dq_oe) v_dq++;
    if ((!sram_ce_n || !flash_ce_n) && mem_addr != cur_addr) v_addr++;
    if (sram_we_n != 4'hF || flash_we_n != 4'hF) begin
      we_len++;
      we_mask |= ~(sram_we_n & flash_we_n);
      if (sram_we_n != 4'hF) we_s = 1;
      if (flash_we_n != 4'hF) we_f = 1;
    end
    if (!mem_oe_n) oe_len++;
    if (mem_dq_oe) dq_len++;
    if (!sram_ce_n) saw_s = 1;
    if (!flash_ce_n) saw_f = 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(input int t, input int i);
    return (32'h1357_0000 * (t + 1)) ^ (32'h0101_0101 * i) ^ 32'h5A00_00C3;
  endfunction

  task automatic access(input bit fl, input bit wr, input logic [18:0] a,
                        input logic [31:0] d, input logic [3:0] be);
    int g, n, exp_lat, lat;
    bit busy_bad;
    string gtag;
    logic [31:0] exp_rd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (have_prev && (p_fl != fl || p_wr != wr)) begin g = T_TURN; gtag = "R7"; end
    else if (have_prev && p_fl && p_wr && fl && wr) begin g = T_WPH; gtag = "R8"; end
    else begin g = 0; gtag = "R10"; end
    n = fl ? (wr ? T_FW : T_FR) : (wr ? T_SW : T_SR);
    exp_lat = g + n + (wr ? T_HOLD : 0);
    exp_rd = fl ? shd_f[a[3:0]] : shd_s[a[3:0]];
    we_len = 0; oe_len = 0; dq_len = 0; we_mask = 0;
    we_s = 0; we_f = 0; saw_s = 0; saw_f = 0;
    cur_addr = a;
    req_valid = 1; req_flash = fl; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0; busy_bad = 0;
    while (!done && lat < 1000) begin
      if (req_ready) busy_bad = 1;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk(lat == exp_lat, gtag, "done latency (gap+strobe+hold)", lat, exp_lat);
    chk(!busy_bad && req_ready, "R9", "ready low while busy, high at done", {busy_bad, req_ready}, 32'h1);
    chk(saw_s == !fl && saw_f == fl, "R6", "only target chip enable asserted", {saw_s, saw_f}, {!fl, fl});
    if (!wr) begin
      chk(rd_data == exp_rd, fl ? "R3" : "R2", "read data", rd_data, exp_rd);
      chk(oe_len == n, fl ? "R3" : "R2", "output enable width", oe_len, n);
      chk(we_len == 0 && dq_len == 0, "R5", "no strobe or driver on read", we_len + dq_len, 0);
    end else begin
      chk(we_len == (be != 0 ? n : 0), "R4", "write pulse width", we_len, be != 0 ? n : 0);
      chk(we_mask == be, "R4", "strobed lanes", we_mask, be);
      chk(!(fl ? we_s : we_f), "R4", "other type write enables idle", {we_s, we_f}, 0);
      chk(dq_len == n + T_HOLD, "R5", "driver window", dq_len, n + T_HOLD);
      chk(oe_len == 0, "R5", "output enable idle on write", oe_len, 0);
      for (int l = 0; l < 4; l++)
        if (be[l]) begin
          if (fl) shd_f[a[3:0]][l*8 +: 8] = d[l*8 +: 8];
          else    shd_s[a[3:0]][l*8 +: 8] = d[l*8 +: 8];
        end
    end
    @(negedge clk);
    chk(!done, "R9", "done is one cycle", done, 0);
    have_prev = 1; p_fl = fl; p_wr = wr;
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    int k;
    for (int i = 0; i < 16; i++) begin
      dev_s[i] = init_val(0, i); shd_s[i] = dev_s[i];
      dev_f[i] = init_val(1, i); shd_f[i] = dev_f[i];
    end
    rst_n = 0; req_valid = 0; req_write = 0; req_flash = 0;
    req_addr = '0; req_wdata = '0; req_be = '0; cur_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sram_ce_n && flash_ce_n && mem_oe_n && sram_we_n == 4'hF && flash_we_n == 4'hF,
        "R1", "enables inactive after reset", {sram_ce_n, flash_ce_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe && !done && req_ready, "R1", "driver off, idle after reset",
        {mem_dq_oe, done, req_ready}, 3'b001);
    k = 0;
    for (int rep = 0; rep < 2; rep++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          access(a[1], a[0], 19'(k * 12345 + 7), 32'(k) * 32'h9E37_79B9 + 32'(rep), 4'(k));
          k++;
          access(b[1], b[0], 19'(k * 12345 + 7), 32'(k) * 32'h9E37_79B9 + 32'(rep), 4'(k));
          k++;
        end
    for (int i = 0; i < 16; i++) begin
      access(0, 0, 19'(i + 16 * i), 32'h0, 4'h0);
      access(1, 0, 19'(i + 32 * i), 32'h0, 4'h0);
    end
    chk(v_ce == 0, "R6", "both chip enables low", v_ce, 0);
    chk(v_dq == 0, "R5", "driver outside write window", v_dq, 0);
    chk(v_addr == 0, "R5", "address moved while enabled", v_addr, 0);
    summary();
  end
endmodule